// File: doc/BRIEF.md
# Dual-Direction UART Buffer with Fill-Level Triggers

This block holds the bytes that travel between a register-style data port and the serial shifters of a UART. It contains two independent queues. The transmit queue takes 8-bit bytes written by the bus side and hands them, oldest first, to the serializer. The receive queue takes 12-bit words from the deserializer and hands them to the bus side. Each receive word is an 8-bit data byte with 4 error flag bits above it. Both queues present their oldest entry at the output while they are not empty, and a pop strobe advances them.

A single enable input selects how deep the queues are. When it is low, each direction works as a holding register one entry deep. When it is high, each direction holds up to 16 entries. Each direction has its own 3-bit fill-level select, which drives a trigger output that an interrupt controller can use. The receive trigger signals that enough words are waiting. The transmit trigger signals that the transmit queue has drained far enough to take more. The receive side also has a sticky overrun flag for words that arrive when there is no room for them.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty and not full, the overrun flag is clear, the receive trigger is low and the transmit trigger is high.
- R2: With `fifo_en` high, each queue accepts 16 entries, raises its full flag at 16, and returns the entries in the order they were written.
- R3: A push into a full queue leaves its stored entries and its output unchanged. A pop from an empty queue leaves the queue empty.
- R4: With `fifo_en` low, each queue holds one entry: it is full after one push, and a second push is not stored.
- R5: A receive word is carried whole: bits 11:8 hold the 4 error flags and bits 7:0 hold the data byte, both returned unchanged.
- R6: A receive push while the receive queue is full sets `rx_overrun` and discards the word. The flag stays set until an `ovr_clr` pulse, and a new overrun in the same cycle as `ovr_clr` wins.
- R7: The level select codes map to entry counts of the 16-entry queue as follows: 0 = 2, 1 = 4, 2 = 8, 3 = 12, 4 = 14. Codes 5, 6 and 7 select 8.
- R8: With `fifo_en` high, `rx_trig` is high while the receive count is at or above its level, and `tx_trig` is high while the transmit count is at or below its level. With `fifo_en` low, `rx_trig` means not empty and `tx_trig` means empty.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full store the new entry, remove the oldest one and leave the count unchanged.
- R10: While a queue is not empty, its read data output shows the oldest entry without a pop being needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | High: 16-entry queues; low: single-entry holding registers |
| tx_lvl_sel | input | 3 | Transmit trigger level code |
| rx_lvl_sel | input | 3 | Receive trigger level code |
| tx_wr | input | 1 | Bus-side push strobe for the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_rd | input | 1 | Serializer pop strobe for the transmit queue |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_trig | output | 1 | Transmit fill-level trigger |
| rx_wr | input | 1 | Deserializer push strobe for the receive queue |
| rx_wdata | input | 12 | Flags (11:8) and data byte (7:0) to push |
| rx_rd | input | 1 | Bus-side pop strobe for the receive queue |
| rx_rdata | output | 12 | Oldest receive word |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_trig | output | 1 | Receive fill-level trigger |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |

## Verification
The trigger logic is driven through a table that fills both queues to counts just below, at and just above each selectable level. This separates an off-by-one in the comparison from a wrong level decode, including the codes that must fall back to the half mark. Directed sequences then write distinct, numbered patterns, so that a lost entry, a reordered entry or a corrupted flag nibble shows up as a mismatch at a known position. Pushes on a full queue, pops on an empty queue and simultaneous push and pop are each followed by reading back the whole queue. Every depth-related behaviour is tried in both modes, which separates the single-entry holding register from the full 16-entry queue.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Map a 3-bit level code to an entry count for a queue of the given depth.
    function automatic int unsigned lvl_count(input logic [2:0] code, input int unsigned depth);
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd3:    return (3 * depth) / 4;
            3'd4:    return (7 * depth) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             push_drop
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            count;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0] cap;
    logic             do_push;
    logic             do_pop;

    assign cap       = single ? CNT_W'(1) : CNT_W'(DEPTH);
    assign empty     = (s_q.count == '0);
    assign full      = (s_q.count >= cap);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign rdata     = s_q.mem[s_q.rd_ptr];
    assign count     = s_q.count;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wr_ptr] = wdata;
            s_d.wr_ptr = (s_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr_ptr + PTR_W'(1);
        end
        if (do_pop) begin
            s_d.rd_ptr = (s_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd_ptr + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.count = s_q.count + CNT_W'(1);
            2'b01:   s_d.count = s_q.count - CNT_W'(1);
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter bit RX_SIDE = 1'b1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [2:0]       sel,
    input  logic [CNT_W-1:0] count,
    input  logic             fifo_en,
    output logic             trig
);

    logic [CNT_W-1:0] level;

    assign level = CNT_W'(lvl_count(sel, DEPTH));

    generate
        if (RX_SIDE) begin : g_rx
            assign trig = fifo_en ? (count >= level) : (count != '0);
        end else begin : g_tx
            assign trig = fifo_en ? (count <= level) : (count == '0);
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int FLAG_W = 4,
    localparam int RX_W  = DATA_W + FLAG_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [2:0]        tx_lvl_sel,
    input  logic [2:0]        rx_lvl_sel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_rd,
    output logic [DATA_W-1:0] tx_rdata,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_trig,
    input  logic              rx_wr,
    input  logic [RX_W-1:0]   rx_wdata,
    input  logic              rx_rd,
    output logic [RX_W-1:0]   rx_rdata,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_trig,
    output logic              rx_overrun,
    input  logic              ovr_clr
);

    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t f_d, f_q;

    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] rx_count;
    logic             tx_drop;
    logic             rx_drop;

    uart_fifo_core #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .single    (!fifo_en),
        .push      (tx_wr),
        .wdata     (tx_wdata),
        .pop       (tx_rd),
        .rdata     (tx_rdata),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full),
        .push_drop (tx_drop)
    );

    uart_fifo_core #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .single    (!fifo_en),
        .push      (rx_wr),
        .wdata     (rx_wdata),
        .pop       (rx_rd),
        .rdata     (rx_rdata),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full),
        .push_drop (rx_drop)
    );

    uart_fifo_trig #(.DEPTH(DEPTH), .RX_SIDE(1'b0)) u_tx_trig (
        .sel     (tx_lvl_sel),
        .count   (tx_count),
        .fifo_en (fifo_en),
        .trig    (tx_trig)
    );

    uart_fifo_trig #(.DEPTH(DEPTH), .RX_SIDE(1'b1)) u_rx_trig (
        .sel     (rx_lvl_sel),
        .count   (rx_count),
        .fifo_en (fifo_en),
        .trig    (rx_trig)
    );

    // Sticky overrun: a new overrun in the clear cycle takes priority.
    always_comb begin
        f_d = f_q;
        if (ovr_clr) begin
            f_d.ovr = 1'b0;
        end
        if (rx_drop) begin
            f_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rx_overrun = f_q.ovr;

    // The transmit side has no overrun report; a dropped push is simply lost.
    logic unused_tx_drop;
    assign unused_tx_drop = tx_drop;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int RX_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fifo_en,
    input logic            tx_rd,
    input logic            tx_wr,
    input logic            tx_empty,
    input logic            tx_trig,
    input logic            rx_wr,
    input logic            rx_rd,
    input logic [RX_W-1:0] rx_rdata,
    input logic            rx_empty,
    input logic            rx_full,
    input logic            rx_trig,
    input logic            rx_overrun,
    input logic            ovr_clr
);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && rx_full) |=> rx_overrun);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(rx_wr && rx_full)) |=> !rx_overrun);

    assert_drop_keeps_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_wr && !rx_rd) |=> $stable(rx_rdata));

    assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && tx_rd && !tx_wr) |=> tx_empty);

    assert_bypass_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_empty && rx_wr && !rx_rd) |=> (fifo_en || rx_full));

    assert_tx_trig_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_trig);

    assert_rx_trig_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !rx_trig);

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.RX_W(RX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .tx_rd      (tx_rd),
    .tx_wr      (tx_wr),
    .tx_empty   (tx_empty),
    .tx_trig    (tx_trig),
    .rx_wr      (rx_wr),
    .rx_rd      (rx_rd),
    .rx_rdata   (rx_rdata),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rx_trig    (rx_trig),
    .rx_overrun (rx_overrun),
    .ovr_clr    (ovr_clr)
);

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [2:0]  tx_lvl_sel = 3'd2;
    logic [2:0]  rx_lvl_sel = 3'd2;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        tx_rd = 1'b0;
    logic [7:0]  tx_rdata;
    logic        tx_empty, tx_full, tx_trig;
    logic        rx_wr = 1'b0;
    logic [11:0] rx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [11:0] rx_rdata;
    logic        rx_empty, rx_full, rx_trig, rx_overrun;
    logic        ovr_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd), .tx_rdata(tx_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_trig(tx_trig),
        .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_trig(rx_trig),
        .rx_overrun(rx_overrun), .ovr_clr(ovr_clr)
    );

    typedef struct packed {
        logic [2:0] sel;
        logic [4:0] cnt;
        logic       rx;
        logic       tx;
    } vec_t;

    // Level per R7: code0=2 code1=4 code2=8 code3=12 code4=14, codes 5..7=8.
    localparam vec_t VEC [13] = '{
        '{3'd0, 5'd1,  1'b0, 1'b1},
        '{3'd0, 5'd2,  1'b1, 1'b1},
        '{3'd0, 5'd3,  1'b1, 1'b0},
        '{3'd1, 5'd3,  1'b0, 1'b1},
        '{3'd1, 5'd4,  1'b1, 1'b1},
        '{3'd2, 5'd7,  1'b0, 1'b1},
        '{3'd2, 5'd8,  1'b1, 1'b1},
        '{3'd2, 5'd9,  1'b1, 1'b0},
        '{3'd3, 5'd12, 1'b1, 1'b1},
        '{3'd4, 5'd13, 1'b0, 1'b1},
        '{3'd4, 5'd15, 1'b1, 1'b0},
        '{3'd6, 5'd8,  1'b1, 1'b1},
        '{3'd7, 5'd7,  1'b0, 1'b1}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0; ovr_clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_tx();
        tx_rd = 1'b1;
        @(negedge clk);
        tx_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [11:0] w);
        rx_wr = 1'b1; rx_wdata = w;
        @(negedge clk);
        rx_wr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 tx_trig", tx_trig, 1);

        // R7 / R8: level table
        foreach (VEC[i]) begin
            do_reset();
            fifo_en = 1'b1;
            tx_lvl_sel = VEC[i].sel;
            rx_lvl_sel = VEC[i].sel;
            for (int k = 0; k < int'(VEC[i].cnt); k++) begin
                tx_wr = 1'b1; tx_wdata = 8'(k);
                rx_wr = 1'b1; rx_wdata = 12'(k);
                @(negedge clk);
                tx_wr = 1'b0; rx_wr = 1'b0;
            end
            chk($sformatf("R7 R8 rx_trig vec%0d", i), rx_trig, VEC[i].rx);
            chk($sformatf("R7 R8 tx_trig vec%0d", i), tx_trig, VEC[i].tx);
        end

        // R2 R3 R5 R6 R10: receive fill, overrun, drain
        do_reset();
        fifo_en = 1'b1; rx_lvl_sel = 3'd2;
        for (int k = 0; k < 16; k++) push_rx({4'(k), 8'(8'h30 + k)});
        chk("R2 rx_full at 16", rx_full, 1);
        chk("R6 no overrun yet", rx_overrun, 0);
        push_rx(12'hFFF);
        chk("R6 overrun set", rx_overrun, 1);
        chk("R3 head kept on full push", rx_rdata, {4'h0, 8'h30});
        for (int k = 0; k < 16; k++) begin
            chk($sformatf("R5 R10 rx word %0d", k), rx_rdata, {4'(k), 8'(8'h30 + k)});
            pop_rx();
        end
        chk("R2 rx_empty after drain", rx_empty, 1);
        chk("R6 overrun sticky", rx_overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R6 overrun cleared", rx_overrun, 0);

        // R4 R6 R8: receive holding register
        fifo_en = 1'b0;
        push_rx(12'hA5C);
        chk("R4 rx full after one", rx_full, 1);
        chk("R8 bypass rx_trig", rx_trig, 1);
        rx_wr = 1'b1; rx_wdata = 12'h123; ovr_clr = 1'b1;
        @(negedge clk);
        rx_wr = 1'b0; ovr_clr = 1'b0;
        chk("R6 set wins over clear", rx_overrun, 1);
        chk("R4 rx holder kept", rx_rdata, 12'hA5C);
        pop_rx();
        chk("R4 rx empty after pop", rx_empty, 1);

        // R4 R8: transmit holding register
        do_reset();
        fifo_en = 1'b0;
        push_tx(8'hA1);
        push_tx(8'hB2);
        chk("R4 tx full after one", tx_full, 1);
        chk("R8 bypass tx_trig low", tx_trig, 0);
        chk("R4 tx holder kept", tx_rdata, 8'hA1);
        pop_tx();
        chk("R4 tx empty after pop", tx_empty, 1);
        chk("R8 bypass tx_trig empty", tx_trig, 1);

        // R3 R2: transmit pop on empty, overfill
        do_reset();
        fifo_en = 1'b1;
        pop_tx();
        chk("R3 pop on empty", tx_empty, 1);
        for (int k = 0; k < 16; k++) push_tx(8'(8'h50 + k));
        chk("R2 tx_full at 16", tx_full, 1);
        push_tx(8'hEE);
        for (int k = 0; k < 16; k++) begin
            chk($sformatf("R3 tx byte %0d", k), tx_rdata, 8'(8'h50 + k));
            pop_tx();
        end
        chk("R3 tx empty after 16", tx_empty, 1);

        // R9: simultaneous push and pop
        do_reset();
        fifo_en = 1'b1; tx_lvl_sel = 3'd0;
        push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
        tx_wr = 1'b1; tx_wdata = 8'h04; tx_rd = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0; tx_rd = 1'b0;
        chk("R9 count held (trig low at 3)", tx_trig, 0);
        chk("R9 head advanced", tx_rdata, 8'h02);
        pop_tx();
        chk("R9 trig at 2", tx_trig, 1);
        chk("R9 second", tx_rdata, 8'h03);
        pop_tx();
        chk("R9 third", tx_rdata, 8'h04);
        chk("R9 not empty", tx_empty, 0);
        pop_tx();
        chk("R9 empty after 3 pops", tx_empty, 1);

        summary();
        $finish;
    end

endmodule